// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter that needs no hardware multiplier. A whole sample word enters on a valid/ready stream and a whole result word leaves on another. Inside, the datapath consumes one bit position per clock from every stored sample at once. Those bits, or the bits of a running bit-serial sum of the two samples that share a coefficient, address small precomputed tables. Each table entry is the sum of the coefficients whose address bit is set. The outputs of all the tables are summed, and a shift-right accumulator weights each bit position by its power of two. The sign-bit position is subtracted rather than added, so two's complement samples come out exact.

The coefficients are a parameter and are fixed at elaboration. With symmetric coefficients, each mirrored tap pair goes through one table address line, which halves the table inputs. That mode costs one extra clock per sample for the carry-out of the serial pre-add. The filter therefore takes one sample every `DATA_W` clocks, or every `DATA_W+1` clocks in symmetric mode. The result keeps full precision, and the output width does not depend on any setting that changes the logic.

Stream rules: a sample is taken on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is low while a sample is being worked on, except in its final cycle when that result can be handed over. A result sits on `m_data` with `m_valid` high until `m_ready` takes it. If the previous result has not been taken, the engine waits in its final cycle, and no result is ever dropped or overwritten.

Top module: `da_fir_serial`

## Requirements
- R1: After reset, `m_valid` is 0 and `s_ready` is 1. Every stored sample is zero, so an impulse of value 1 followed by zeros returns the coefficients in tap order (tap 0 first).
- R2: A sample is taken only on an edge with `s_valid` and `s_ready` both high. In the cycle after a sample is taken, `s_ready` is 0.
- R3: Each result equals the sum over k of c[k]·x[n−k], where x[n] is the newest sample. Samples are `DATA_W`-bit two's complement, coefficients are `COEF_W`-bit two's complement packed with tap k at bits [k·COEF_W +: COEF_W], and `m_data` is the exact two's complement value.
- R4: With `m_ready` held high and samples always offered, one sample is taken every STEPS cycles, where STEPS = `DATA_W`+1 when `SYMMETRIC`=1 and `DATA_W` otherwise. `m_valid` rises exactly STEPS edges after the edge that took the sample.
- R5: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data` does not change.
- R6: A result that finishes while the previous one is still held does not replace it. The engine waits with `s_ready` at 0, and its result appears on `m_data` in the cycle after the held one is taken.
- R7: With `SYMMETRIC`=0, every tap uses its own coefficient, which need not be symmetric, and the result is ready after `DATA_W` cycles.
- R8: Samples at the extremes, −2^(DATA_W−1) and 2^(DATA_W−1)−1, in every tap give exact results, including the pre-add of two such samples in symmetric mode.
- R9: When a result is taken and no further result is waiting, `m_valid` is 0 in the next cycle. With `m_ready` high, each result is valid for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-level clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Filter can take a sample this cycle |
| s_data | input | DATA_W | Two's complement input sample |
| m_valid | output | 1 | Result held on m_data |
| m_ready | input | 1 | Downstream takes the result |
| m_data | output | RES_W | Full-precision two's complement result (21 bits at defaults) |

## Verification
A wrong bit in the time-skew line or in a pre-add carry corrupts the result of the sample it belongs to. For a skew-line bit, the error repeats for every later sample until that word leaves the line, so an impulse test shows it as a wrong coefficient in a known position. An off-by-one in the step counter moves the `m_valid` rise away from STEPS edges, and it also breaks the sign subtraction. That shows up in the first result, as a wrong value for negative samples. An accumulator or stall fault shows in the first result that arrives under back-pressure, as a changed held value or a lost result.

// File: rtl/da_fir_pkg.sv
`timescale 1ns/1ps
package da_fir_pkg;

  // ceiling of a/b for positive operands
  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // number of table address lines: one per tap, or one per mirrored pair
  function automatic int addr_lines(input int ntaps, input int sym);
    return (sym != 0) ? (ntaps + 1) / 2 : ntaps;
  endfunction

  // bit clocks needed per sample
  function automatic int steps_per_sample(input int data_w, input int sym);
    return (sym != 0) ? data_w + 1 : data_w;
  endfunction

endpackage

// File: rtl/da_fir_skew.sv
`timescale 1ns/1ps
// Time-skew line plus bit selection and optional serial pre-adders.
module da_fir_skew #(
  parameter int DATA_W    = 8,
  parameter int NTAPS     = 8,
  parameter int SYMMETRIC = 1,
  parameter int NADDR     = 4,
  parameter int STEP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] din,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  output logic [NADDR-1:0]  addr
);

  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [STEP_W-1:0] SIGN_POS = STEP_W'(DATA_W - 1);

  logic [DATA_W-1:0] line [NTAPS];
  logic [BW-1:0]     bsel;
  logic              first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) line[i] <= '0;
    end else if (shift_en) begin
      line[0] <= din;
      for (int i = 1; i < NTAPS; i++) line[i] <= line[i-1];
    end
  end

  // beyond the sign position the sign bit repeats (sign extension)
  always_comb begin
    if (step > SIGN_POS) bsel = BW'(DATA_W - 1);
    else                 bsel = step[BW-1:0];
  end

  assign first = (step == '0);

  generate
    if (SYMMETRIC != 0) begin : g_sym
      for (genvar p = 0; p < NADDR; p++) begin : g_pair
        logic a_bit, b_bit, cin, carry_q;
        assign a_bit = line[p][bsel];
        if (NTAPS - 1 - p != p) begin : g_two
          assign b_bit = line[NTAPS-1-p][bsel];
        end else begin : g_mid
          assign b_bit = 1'b0;
        end
        assign cin     = first ? 1'b0 : carry_q;
        assign addr[p] = a_bit ^ b_bit ^ cin;
        always_ff @(posedge clk) begin
          if (!rst_n)   carry_q <= 1'b0;
          else if (adv) carry_q <= (a_bit & b_bit) | (a_bit & cin) | (b_bit & cin);
        end
      end
    end else begin : g_plain
      for (genvar p = 0; p < NADDR; p++) begin : g_tap
        assign addr[p] = line[p][bsel];
      end
    end
  endgenerate

endmodule

// File: rtl/da_fir_table.sv
`timescale 1ns/1ps
// One coefficient-sum lookup table covering LUT_IN address lines.
module da_fir_table #(
  parameter int LUT_IN = 4,
  parameter int COEF_W = 8,
  parameter int TAB_W  = 10,
  parameter int NADDR  = 4,
  parameter int NTAPS  = 8,
  parameter int BASE   = 0,
  parameter logic [NTAPS*COEF_W-1:0] COEF_VEC = '0
) (
  input  logic [LUT_IN-1:0]       addr,
  output logic signed [TAB_W-1:0] value
);

  localparam int DEPTH = 1 << LUT_IN;

  function automatic logic signed [TAB_W-1:0] entry(input int e);
    logic signed [TAB_W-1:0] s;
    logic signed [COEF_W-1:0] c;
    s = '0;
    for (int j = 0; j < LUT_IN; j++) begin
      if ((((e >> j) & 1) == 1) && (BASE + j < NADDR)) begin
        c = COEF_VEC[(BASE+j)*COEF_W +: COEF_W];
        s = s + TAB_W'(c);
      end
    end
    return s;
  endfunction

  logic signed [TAB_W-1:0] rom [DEPTH];

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      localparam logic signed [TAB_W-1:0] VAL = entry(e);
      assign rom[e] = VAL;
    end
  endgenerate

  assign value = rom[addr];

endmodule

// File: rtl/da_fir_accum.sv
`timescale 1ns/1ps
// Shift-right accumulator: each partial enters at the top, sign step subtracts.
module da_fir_accum #(
  parameter int SUM_W = 11,
  parameter int RES_W = 21,
  parameter int STEPS = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    first,
  input  logic                    last,
  input  logic                    fin,
  input  logic signed [SUM_W-1:0] partial,
  output logic signed [RES_W-1:0] result
);

  logic signed [RES_W-1:0] acc, base, ext, term, nxt;

  always_comb begin
    base = first ? '0 : acc;
    ext  = RES_W'(partial);
    term = last ? -ext : ext;
    nxt  = (base >>> 1) + (term <<< (STEPS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      result <= '0;
    end else begin
      if (adv) acc <= nxt;
      if (fin) result <= nxt;
    end
  end

  // R3: the scaling never drops a set bit when it shifts right
  a_r3_exact_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !first) |-> (acc[0] == 1'b0));

endmodule

// File: rtl/da_fir_serial.sv
`timescale 1ns/1ps
module da_fir_serial #(
  parameter int DATA_W    = 8,
  parameter int NTAPS     = 8,
  parameter int COEF_W    = 8,
  parameter int SYMMETRIC = 1,
  parameter int LUT_IN    = 4,
  parameter logic [NTAPS*COEF_W-1:0] COEF_VEC = 64'hFD050C14140C05FD,
  localparam int NADDR  = da_fir_pkg::addr_lines(NTAPS, SYMMETRIC),
  localparam int NTAB   = da_fir_pkg::ceil_div(NADDR, LUT_IN),
  localparam int STEPS  = da_fir_pkg::steps_per_sample(DATA_W, SYMMETRIC),
  localparam int TAB_W  = COEF_W + $clog2(LUT_IN),
  localparam int SUM_W  = TAB_W + $clog2(NTAB) + 1,
  localparam int RES_W  = SUM_W + STEPS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [RES_W-1:0]  m_data
);

  localparam int STEP_W = $clog2(STEPS + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  logic              busy;
  logic [STEP_W-1:0] step;
  logic              last, first, out_free, adv, fin, take;

  assign last     = (step == LAST_STEP);
  assign first    = (step == '0);
  assign out_free = !m_valid || m_ready;
  assign adv      = busy && (!last || out_free);
  assign fin      = busy && last && out_free;
  assign s_ready  = !busy || fin;
  assign take     = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (take) begin
      busy <= 1'b1;
      step <= '0;
    end else if (fin) begin
      busy <= 1'b0;
    end else if (adv) begin
      step <= step + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 m_valid <= 1'b0;
    else if (fin)               m_valid <= 1'b1;
    else if (m_valid && m_ready) m_valid <= 1'b0;
  end

  // ---- datapath ----
  logic [NADDR-1:0]       addr;
  logic [NTAB*LUT_IN-1:0] addr_pad;
  logic signed [TAB_W-1:0] tab_out [NTAB];
  logic signed [SUM_W-1:0] psum;
  logic signed [RES_W-1:0] res;

  da_fir_skew #(
    .DATA_W(DATA_W), .NTAPS(NTAPS), .SYMMETRIC(SYMMETRIC),
    .NADDR(NADDR), .STEP_W(STEP_W)
  ) u_skew (
    .clk(clk), .rst_n(rst_n), .shift_en(take), .din(s_data),
    .adv(adv), .step(step), .addr(addr)
  );

  always_comb begin
    addr_pad = '0;
    addr_pad[NADDR-1:0] = addr;
  end

  generate
    for (genvar g = 0; g < NTAB; g++) begin : g_tab
      da_fir_table #(
        .LUT_IN(LUT_IN), .COEF_W(COEF_W), .TAB_W(TAB_W), .NADDR(NADDR),
        .NTAPS(NTAPS), .BASE(g * LUT_IN), .COEF_VEC(COEF_VEC)
      ) u_table (
        .addr(addr_pad[g*LUT_IN +: LUT_IN]),
        .value(tab_out[g])
      );
    end
  endgenerate

  always_comb begin
    psum = '0;
    for (int g = 0; g < NTAB; g++) psum = psum + SUM_W'(tab_out[g]);
  end

  da_fir_accum #(.SUM_W(SUM_W), .RES_W(RES_W), .STEPS(STEPS)) u_accum (
    .clk(clk), .rst_n(rst_n), .adv(adv), .first(first), .last(last),
    .fin(fin), .partial(psum), .result(res)
  );

  assign m_data = res;

  // ---- assertions ----
  logic [STEP_W:0] lat;
  always_ff @(posedge clk) begin
    if (!rst_n)                    lat <= '0;
    else if (take)                 lat <= '0;
    else if (lat != '1)            lat <= lat + 1'b1;
  end

  // R2: taking a sample closes the input for the next cycle
  a_r2_closed_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !s_ready);

  // R4: a result never finishes before STEPS cycles of work
  a_r4_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (lat >= (STEP_W+1)'(STEPS - 1)));

  // R5: held result stays put under back-pressure
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R9: a taken result with nothing pending clears valid
  a_r9_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !busy) |=> !m_valid);

endmodule

// File: tb/da_fir_serial_bench.sv
`timescale 1ns/1ps
module da_fir_serial_bench;

  localparam int DW = 8;
  localparam int RW = 21;
  localparam int STEPS_S = 9;
  localparam int STEPS_A = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // symmetric instance
  logic sv_s = 0, sr_s, mv_s, mr_s = 1;
  logic [DW-1:0] sd_s = '0;
  logic [RW-1:0] md_s;
  // non-symmetric instance
  logic sv_a = 0, sr_a, mv_a, mr_a = 1;
  logic [DW-1:0] sd_a = '0;
  logic [RW-1:0] md_a;

  da_fir_serial #(.SYMMETRIC(1), .COEF_VEC(64'hFD050C14140C05FD)) u_da_fir_serial (
    .clk(clk), .rst_n(rst_n), .s_valid(sv_s), .s_ready(sr_s), .s_data(sd_s),
    .m_valid(mv_s), .m_ready(mr_s), .m_data(md_s));

  da_fir_serial #(.SYMMETRIC(0), .COEF_VEC(64'h03FA0104F70FFE07)) u_da_fir_serial_asym (
    .clk(clk), .rst_n(rst_n), .s_valid(sv_a), .s_ready(sr_a), .s_data(sd_a),
    .m_valid(mv_a), .m_ready(mr_a), .m_data(md_a));

  int cs[8] = '{-3, 5, 12, 20, 20, 12, 5, -3};
  int ca[8] = '{7, -2, 15, -9, 4, 1, -6, 3};
  int hs[8];
  int ha[8];
  int errors = 0;
  int checks = 0;
  int unsigned lcg = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) & 32'hFF) - 128;
  endfunction

  function automatic int rs(); int v; v = $signed(md_s); return v; endfunction
  function automatic int ra(); int v; v = $signed(md_a); return v; endfunction

  task automatic commit_s(input int x, output int y);
    for (int i = 7; i > 0; i--) hs[i] = hs[i-1];
    hs[0] = x;
    y = 0;
    for (int i = 0; i < 8; i++) y += cs[i] * hs[i];
  endtask

  task automatic commit_a(input int x, output int y);
    for (int i = 7; i > 0; i--) ha[i] = ha[i-1];
    ha[0] = x;
    y = 0;
    for (int i = 0; i < 8; i++) y += ca[i] * ha[i];
  endtask

  // offer one sample to the symmetric instance; returns the cycle it was taken
  task automatic feed_s(input int x, output int c_take, output int y);
    @(negedge clk);
    sv_s = 1'b1; sd_s = DW'(x);
    while (!sr_s) @(negedge clk);
    c_take = cyc;
    commit_s(x, y);
    @(negedge clk);
    sv_s = 1'b0;
  endtask

  task automatic feed_check_s(input int x, input string req);
    int c, y, n;
    feed_s(x, c, y);
    n = 0;
    while (!mv_s && n < 40) begin @(negedge clk); n++; end
    chk(cyc == c + STEPS_S + 1, "R4 latency", cyc - c - 1, STEPS_S);
    chk(rs() == y, req, rs(), y);
    @(negedge clk);
    chk(!mv_s, "R9 single beat", int'(mv_s), 0);
  endtask

  task automatic feed_check_a(input int x, input string req);
    int c, y, n;
    @(negedge clk);
    sv_a = 1'b1; sd_a = DW'(x);
    while (!sr_a) @(negedge clk);
    c = cyc;
    commit_a(x, y);
    @(negedge clk);
    sv_a = 1'b0;
    n = 0;
    while (!mv_a && n < 40) begin @(negedge clk); n++; end
    chk(cyc == c + STEPS_A + 1, "R7 latency", cyc - c - 1, STEPS_A);
    chk(ra() == y, req, ra(), y);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin hs[i] = 0; ha[i] = 0; end
    @(negedge clk);
    chk(mv_s == 1'b0, "R1 m_valid", int'(mv_s), 0);
    chk(sr_s == 1'b1, "R1 s_ready", int'(sr_s), 1);
  endtask

  task automatic t_impulse();
    feed_check_s(1, "R1 impulse tap0");
    for (int k = 1; k < 8; k++) feed_check_s(0, "R1 R3 impulse tap");
  endtask

  task automatic t_patterns();
    int v[6] = '{3, -7, 100, -55, 64, -1};
    foreach (v[i]) feed_check_s(v[i], "R3 pattern");
    for (int i = 0; i < 10; i++) feed_check_s(rnd(), "R3 random");
  endtask

  task automatic t_extremes();
    for (int i = 0; i < 9; i++) feed_check_s(-128, "R8 all min");
    for (int i = 0; i < 9; i++) feed_check_s(127, "R8 all max");
    for (int i = 0; i < 8; i++) feed_check_s((i % 2 == 0) ? 127 : -128, "R8 alternating");
  endtask

  task automatic t_throughput();
    int q[$];
    int n_in = 0, n_out = 0, prev = -1, x = 0, y;
    bit have = 0;
    mr_s = 1'b1;
    while (n_out < 8) begin
      @(negedge clk);
      if (mv_s) begin
        y = q.pop_front();
        chk(rs() == y, "R4 streamed value", rs(), y);
        n_out++;
      end
      if (n_in < 8) begin
        if (!have) begin x = rnd(); have = 1; end
        sv_s = 1'b1; sd_s = DW'(x);
        if (sr_s) begin
          commit_s(x, y);
          q.push_back(y);
          if (prev >= 0) chk(cyc - prev == STEPS_S, "R4 spacing", cyc - prev, STEPS_S);
          prev = cyc;
          n_in++;
          have = 0;
        end
      end else begin
        sv_s = 1'b0;
      end
    end
    sv_s = 1'b0;
  endtask

  task automatic t_backpressure();
    int c, ya, yb, held;
    @(negedge clk);
    mr_s = 1'b0;
    feed_s(41, c, ya);
    repeat (STEPS_S + 4) @(negedge clk);
    chk(mv_s == 1'b1, "R5 valid held", int'(mv_s), 1);
    chk(rs() == ya, "R5 first value", rs(), ya);
    held = rs();
    repeat (6) @(negedge clk);
    chk(rs() == held && mv_s, "R5 stable", rs(), held);
    feed_s(-77, c, yb);
    repeat (STEPS_S + 4) @(negedge clk);
    chk(sr_s == 1'b0, "R6 stalled not ready", int'(sr_s), 0);
    chk(rs() == ya, "R6 old value kept", rs(), ya);
    mr_s = 1'b1;
    @(negedge clk);
    chk(mv_s == 1'b1, "R6 next valid", int'(mv_s), 1);
    chk(rs() == yb, "R6 second value", rs(), yb);
    @(negedge clk);
    chk(mv_s == 1'b0, "R9 cleared", int'(mv_s), 0);
    chk(sr_s == 1'b1, "R2 ready again", int'(sr_s), 1);
  endtask

  task automatic t_asym();
    feed_check_a(1, "R7 impulse tap0");
    for (int k = 1; k < 8; k++) feed_check_a(0, "R7 impulse tap");
    for (int i = 0; i < 8; i++) feed_check_a(-128, "R7 R8 min");
    for (int i = 0; i < 8; i++) feed_check_a(rnd(), "R7 random");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    t_reset();
    t_impulse();
    t_patterns();
    t_extremes();
    t_throughput();
    t_backpressure();
    t_asym();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule